// File: doc/BRIEF.md
# CAN Controller Mode, Status and Interrupt Register Block

This block is the register front end of a CAN controller. It sits between a simple word-addressed read/write port and an abstract protocol engine. Software uses it to pick the operating mode, to set the bit timing while the controller is held in reset mode, to issue one-cycle commands to the engine, to read a status word, and to handle interrupts. The engine reports its events on single-cycle inputs: frame received, transmission done, overrun, error warning, error passive, bus error, arbitration lost and wake-up. It also reports its busy and bus-off levels, and it asks for error-counter steps.

The block keeps a small count of received frames that are waiting to be released. It owns the transmit and receive error counters. When a bus error occurs it captures the error type, the direction and the frame segment code. When arbitration is lost it captures the bit position. Interrupt flags are cleared by writing one to them, and a single interrupt line combines the flags with their enables. Register offsets: 0x00 mode, 0x04 command, 0x08 status, 0x0C interrupt flags, 0x10 interrupt enable, 0x14 bit timing, 0x1C error counters.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset the mode register reads 0x01, so the controller is in reset mode. Status reads 0x3C. Interrupt flags, interrupt enables and both error counters read 0, and irq is low.
- R2: Mode bit 0 is reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter and bit 4 sleep. Bits 2:0 take every write. Bits 4:3 change only when bit 0 was already set before the write.
- R3: The bit-timing register at 0x14 keeps only the bits in mask 0x00FFC3FF. It accepts writes only while reset mode is set. cfg_timing shows its value.
- R4: Status bit 4 (receive busy) and bit 5 (transmit busy) are high while the engine is busy or reset mode is set. Bit 7 follows eng_bus_off. Bit 6 is high while either error count is at least WARN_LIMIT (default 96).
- R5: Writing to 0x04 outside reset mode drives bits 5:0 of the write data onto cmd_pulse for exactly the one cycle after the write. Bit 0 is transmit, 1 abort, 2 release, 3 clear overrun, 4 self-receive and 5 bus-off request. In reset mode such a write has no effect. Reads of 0x04 return 0.
- R6: A transmit or self-receive command clears status bit 2 (transmit buffer ready) and bit 3 (transmission complete). A transmit-done event sets both bits and interrupt flag 1. An abort command sets bit 2 only.
- R7: Up to RX_DEPTH (default 4) received frames are counted as pending. Status bit 0 is high while any frame is pending, and each release command removes one.
- R8: A frame that arrives while RX_DEPTH frames are pending, or an overrun event, sets status bit 1 and interrupt flag 3. The frame is not counted. A clear-overrun command clears status bit 1.
- R9: The interrupt flag bits are 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wake-up, 5 error passive, 6 arbitration lost and 7 bus error. Writing one to a flag at 0x0C clears it. A flag that is raised in the same cycle as its clear stays set.
- R10: irq is high exactly when some flag bit and its enable bit at 0x10 are both set.
- R11: A bus error captures status bits 23:22 (type: 0 bit, 1 form, 2 stuff, 3 other), bit 21 (direction, 0 means transmit) and bits 20:16 (segment code). An arbitration loss captures the bit position in status bits 12:8.
- R12: The error-counter register holds the transmit count in bits 7:0 and the receive count in bits 23:16. A transmit increment adds 8 and saturates at 255. A receive increment adds 1. Decrements subtract 1 and stop at 0. Writing zero clears both counts, and any other write to the register is ignored.
- R13: Read data appears on rd_data in the cycle after the read request. Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ev_rx_frame | input | 1 | Engine has received a frame |
| ev_tx_done | input | 1 | Engine has finished a transmission |
| ev_err_warn | input | 1 | Error-warning event |
| ev_overrun | input | 1 | Engine-side overrun event |
| ev_wakeup | input | 1 | Wake-up event |
| ev_err_passive | input | 1 | Error-passive event |
| ev_arb_lost | input | 1 | Arbitration-lost event |
| ev_bus_err | input | 1 | Bus-error event |
| berr_type | input | 2 | Type of the bus error |
| berr_dir | input | 1 | Direction of the bus error (0 = transmit) |
| berr_seg | input | 5 | Frame segment code at the bus error |
| arb_pos | input | 5 | Bit position where arbitration was lost |
| eng_rx_busy | input | 1 | Engine is receiving |
| eng_tx_busy | input | 1 | Engine is transmitting |
| eng_bus_off | input | 1 | Engine is bus-off |
| tec_inc | input | 1 | Add 8 to the transmit error count |
| tec_dec | input | 1 | Subtract 1 from the transmit error count |
| rec_inc | input | 1 | Add 1 to the receive error count |
| rec_dec | input | 1 | Subtract 1 from the receive error count |
| cfg_mode | output | 5 | Current mode bits |
| cfg_timing | output | 32 | Current bit-timing value |
| cmd_pulse | output | 6 | One-cycle command strobes to the engine |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, event inputs and counter steps all land on the clock edge where they are sampled. Status, flags and irq therefore show the new value in the following cycle, and a cmd_pulse bit is high in that same cycle and low again one cycle later. Read data is registered once, so a read issued in one cycle returns its value after the next edge. The bench drives every input on the falling edge and samples results on a later falling edge, which puts each check just after the edge where the result becomes due. The same-cycle set/clear case is driven within a single cycle, so that the ordering rule for the flags is actually exercised.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_FLAG  = 8'h0C;
    localparam logic [7:0] OFS_IEN   = 8'h10;
    localparam logic [7:0] OFS_TIME  = 8'h14;
    localparam logic [7:0] OFS_ERRC  = 8'h1C;

    localparam logic [31:0] TIMING_MASK = 32'h00FF_C3FF;
    localparam int          CMD_W       = 6;
    localparam int          FLAG_W      = 8;
    localparam int          MODE_W      = 5;

    typedef enum logic [2:0] {
        SEL_MODE, SEL_CMD, SEL_STAT, SEL_FLAG,
        SEL_IEN,  SEL_TIME, SEL_ERRC, SEL_NONE
    } reg_sel_e;

    // Bit order matters: the packed struct sets the flag bit positions
    typedef struct packed {
        logic bus_err;      // 7
        logic arb_lost;     // 6
        logic err_passive;  // 5
        logic wakeup;       // 4
        logic overrun;      // 3
        logic err_warn;     // 2
        logic tx_done;      // 1
        logic rx_frame;     // 0
    } irq_vec_t;

    typedef struct packed {
        logic bus_off_req;  // 5
        logic self_rx;      // 4
        logic clr_ovr;      // 3
        logic rel_rbuf;     // 2
        logic abort;        // 1
        logic tx_req;       // 0
    } cmd_t;

    typedef struct packed {
        logic sleep;        // 4
        logic single_flt;   // 3
        logic loopback;     // 2
        logic listen;       // 1
        logic rst_mode;     // 0
    } mode_t;

    localparam mode_t MODE_RESET_VAL = '{default: 1'b0, rst_mode: 1'b1};

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            OFS_MODE: return SEL_MODE;
            OFS_CMD:  return SEL_CMD;
            OFS_STAT: return SEL_STAT;
            OFS_FLAG: return SEL_FLAG;
            OFS_IEN:  return SEL_IEN;
            OFS_TIME: return SEL_TIME;
            OFS_ERRC: return SEL_ERRC;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] sat_step(input logic [7:0] v,
                                            input logic       up,
                                            input logic       down,
                                            input logic [7:0] up_amt);
        logic [8:0] sum;
        sum = {1'b0, v} + {1'b0, up_amt};
        if (up)
            return sum[8] ? 8'hFF : sum[7:0];
        else if (down)
            return (v == 8'd0) ? 8'd0 : v - 8'd1;
        else
            return v;
    endfunction

endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
    import can_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_mode,
    input  logic        wr_time,
    input  logic [31:0] wdata,
    output mode_t       mode_o,
    output logic [31:0] timing_o
);
    mode_t       mode_q;
    logic [31:0] timing_q;
    mode_t       mode_wr;

    // Bits 4:3 only follow the write when reset mode was already set
    always_comb begin
        mode_wr = mode_t'(wdata[MODE_W-1:0]);
        if (!mode_q.rst_mode) begin
            mode_wr.sleep      = mode_q.sleep;
            mode_wr.single_flt = mode_q.single_flt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RESET_VAL;
            timing_q <= '0;
        end else begin
            if (wr_mode)
                mode_q <= mode_wr;
            if (wr_time && mode_q.rst_mode)
                timing_q <= wdata & TIMING_MASK;
        end
    end

    assign mode_o   = mode_q;
    assign timing_o = timing_q;

    // R2: the configuration bits stay put outside reset mode
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        !mode_q.rst_mode |=> (mode_q.sleep == $past(mode_q.sleep)) &&
                             (mode_q.single_flt == $past(mode_q.single_flt)));

    // R3: bit timing is frozen outside reset mode
    a_r3_timing_locked: assert property (@(posedge clk) disable iff (rst)
        !mode_q.rst_mode |=> $stable(timing_q));

    // R3: reserved timing bits never set
    a_r3_timing_mask: assert property (@(posedge clk) disable iff (rst)
        (timing_q & ~TIMING_MASK) == 32'd0);

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_vec_t          set_i,
    input  logic              wr_flag,
    input  logic              wr_ien,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] ien_o,
    output logic              irq_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] ien_q;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] set_vec;

    assign set_vec = set_i;
    assign clr_vec = wr_flag ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ien_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (wr_ien)
                ien_q <= wdata;
        end
    end

    assign flags_o = flags_q;
    assign ien_o   = ien_q;
    assign irq_o   = |(flags_q & ien_q);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
        // R9: a raised flag is set on the next cycle, even under a clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags_q[i]);
        // R9: write-one clears when nothing raises it
        a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
        // R10: a disabled flag alone never drives the line
        a_r10_masked: assert property (@(posedge clk) disable iff (rst)
            ($countones(flags_q & ien_q) == 0) |-> !irq_o);
    end

endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
    import can_regs_pkg::*;
#(
    parameter int RX_DEPTH   = 4,
    parameter int WARN_LIMIT = 96
) (
    input  logic        clk,
    input  logic        rst,
    input  cmd_t        cmd_i,
    input  logic        rst_mode_i,
    input  logic        ev_rx_frame,
    input  logic        ev_tx_done,
    input  logic        ev_overrun,
    input  logic        ev_bus_err,
    input  logic        ev_arb_lost,
    input  logic [1:0]  berr_type,
    input  logic        berr_dir,
    input  logic [4:0]  berr_seg,
    input  logic [4:0]  arb_pos,
    input  logic        eng_rx_busy,
    input  logic        eng_tx_busy,
    input  logic        eng_bus_off,
    input  logic        tec_inc,
    input  logic        tec_dec,
    input  logic        rec_inc,
    input  logic        rec_dec,
    input  logic        errc_clr,
    output logic [31:0] status_o,
    output logic [31:0] errc_o,
    output logic        rx_accept_o,
    output logic        ovr_event_o
);
    localparam int CNT_W = $clog2(RX_DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(RX_DEPTH);
    localparam logic [7:0] WARN_C = 8'(WARN_LIMIT);

    logic [CNT_W-1:0] rx_cnt_q;
    logic             ovr_q;
    logic             tbuf_rdy_q;
    logic             tx_cmpl_q;
    logic [7:0]       ecc_q;
    logic [4:0]       alc_q;
    logic [7:0]       tec_q, rec_q;
    logic [7:0]       tec_nx, rec_nx;
    logic             rx_full, push, pop, err_sta;

    assign rx_full     = (rx_cnt_q == DEPTH_C);
    assign push        = ev_rx_frame && !rx_full;
    assign pop         = cmd_i.rel_rbuf && (rx_cnt_q != '0);
    assign rx_accept_o = push;
    assign ovr_event_o = ev_overrun || (ev_rx_frame && rx_full);

    always_comb begin
        tec_nx = sat_step(tec_q, tec_inc, tec_dec, 8'd8);
        rec_nx = sat_step(rec_q, rec_inc, rec_dec, 8'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_cnt_q   <= '0;
            ovr_q      <= 1'b0;
            tbuf_rdy_q <= 1'b1;
            tx_cmpl_q  <= 1'b1;
            ecc_q      <= '0;
            alc_q      <= '0;
            tec_q      <= '0;
            rec_q      <= '0;
        end else begin
            case ({push, pop})
                2'b10:   rx_cnt_q <= rx_cnt_q + 1'b1;
                2'b01:   rx_cnt_q <= rx_cnt_q - 1'b1;
                default: rx_cnt_q <= rx_cnt_q;
            endcase

            if (ovr_event_o)
                ovr_q <= 1'b1;
            else if (cmd_i.clr_ovr)
                ovr_q <= 1'b0;

            if (ev_tx_done) begin
                tbuf_rdy_q <= 1'b1;
                tx_cmpl_q  <= 1'b1;
            end else if (cmd_i.tx_req || cmd_i.self_rx) begin
                tbuf_rdy_q <= 1'b0;
                tx_cmpl_q  <= 1'b0;
            end else if (cmd_i.abort) begin
                tbuf_rdy_q <= 1'b1;
            end

            if (ev_bus_err)
                ecc_q <= {berr_type, berr_dir, berr_seg};
            if (ev_arb_lost)
                alc_q <= arb_pos;

            if (errc_clr) begin
                tec_q <= '0;
                rec_q <= '0;
            end else begin
                tec_q <= tec_nx;
                rec_q <= rec_nx;
            end
        end
    end

    assign err_sta = (tec_q >= WARN_C) || (rec_q >= WARN_C);

    assign status_o = {8'd0, ecc_q, 3'd0, alc_q,
                       eng_bus_off, err_sta,
                       eng_tx_busy | rst_mode_i, eng_rx_busy | rst_mode_i,
                       tx_cmpl_q, tbuf_rdy_q, ovr_q, (rx_cnt_q != '0)};
    assign errc_o   = {8'd0, rec_q, 8'd0, tec_q};

    // R7: pending count never exceeds the depth
    a_r7_rx_bound: assert property (@(posedge clk) disable iff (rst)
        rx_cnt_q <= DEPTH_C);

    // R8: a frame arriving at a full queue shows as overrun next cycle
    a_r8_ovr_on_full: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_frame && rx_full) |=> status_o[1]);

    // R11: bus error type is captured
    a_r11_ecc_capture: assert property (@(posedge clk) disable iff (rst)
        ev_bus_err |=> status_o[23:22] == $past(berr_type));

    // R12: transmit count does not wrap past the top
    a_r12_tec_sat: assert property (@(posedge clk) disable iff (rst)
        (errc_o[7:0] == 8'hFF && tec_inc && !errc_clr) |=> errc_o[7:0] == 8'hFF);

endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
    import can_regs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RX_DEPTH   = 4,
    parameter int WARN_LIMIT = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic              ev_rx_frame,
    input  logic              ev_tx_done,
    input  logic              ev_err_warn,
    input  logic              ev_overrun,
    input  logic              ev_wakeup,
    input  logic              ev_err_passive,
    input  logic              ev_arb_lost,
    input  logic              ev_bus_err,
    input  logic [1:0]        berr_type,
    input  logic              berr_dir,
    input  logic [4:0]        berr_seg,
    input  logic [4:0]        arb_pos,
    input  logic              eng_rx_busy,
    input  logic              eng_tx_busy,
    input  logic              eng_bus_off,
    input  logic              tec_inc,
    input  logic              tec_dec,
    input  logic              rec_inc,
    input  logic              rec_dec,
    output logic [4:0]        cfg_mode,
    output logic [31:0]       cfg_timing,
    output logic [5:0]        cmd_pulse,
    output logic              irq
);
    localparam int AW_PAD = (ADDR_W < 8) ? 8 : ADDR_W;

    reg_sel_e          sel;
    logic              wr, rd;
    logic [AW_PAD-1:0] addr_ext;
    mode_t             mode;
    logic [31:0]       timing;
    cmd_t              cmd_strobe;
    logic [CMD_W-1:0]  cmd_pulse_q;
    logic [31:0]       status, errc;
    logic [FLAG_W-1:0] flags, ien;
    logic              rx_accept, ovr_event;
    irq_vec_t          ev_vec;
    logic [31:0]       rd_next, rd_q;

    assign addr_ext = AW_PAD'(req_addr);
    assign sel      = decode_addr(addr_ext[7:0]);
    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;

    // Command strobes are dropped while the controller sits in reset mode
    assign cmd_strobe = (wr && sel == SEL_CMD && !mode.rst_mode)
                        ? cmd_t'(req_wdata[CMD_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) cmd_pulse_q <= '0;
        else     cmd_pulse_q <= cmd_strobe;
    end

    can_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_mode  (wr && sel == SEL_MODE),
        .wr_time  (wr && sel == SEL_TIME),
        .wdata    (req_wdata),
        .mode_o   (mode),
        .timing_o (timing)
    );

    can_status_unit #(
        .RX_DEPTH   (RX_DEPTH),
        .WARN_LIMIT (WARN_LIMIT)
    ) u_stat (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd_strobe),
        .rst_mode_i  (mode.rst_mode),
        .ev_rx_frame (ev_rx_frame),
        .ev_tx_done  (ev_tx_done),
        .ev_overrun  (ev_overrun),
        .ev_bus_err  (ev_bus_err),
        .ev_arb_lost (ev_arb_lost),
        .berr_type   (berr_type),
        .berr_dir    (berr_dir),
        .berr_seg    (berr_seg),
        .arb_pos     (arb_pos),
        .eng_rx_busy (eng_rx_busy),
        .eng_tx_busy (eng_tx_busy),
        .eng_bus_off (eng_bus_off),
        .tec_inc     (tec_inc),
        .tec_dec     (tec_dec),
        .rec_inc     (rec_inc),
        .rec_dec     (rec_dec),
        .errc_clr    (wr && sel == SEL_ERRC && req_wdata == 32'd0),
        .status_o    (status),
        .errc_o      (errc),
        .rx_accept_o (rx_accept),
        .ovr_event_o (ovr_event)
    );

    always_comb begin
        ev_vec             = '0;
        ev_vec.rx_frame    = rx_accept;
        ev_vec.tx_done     = ev_tx_done;
        ev_vec.err_warn    = ev_err_warn;
        ev_vec.overrun     = ovr_event;
        ev_vec.wakeup      = ev_wakeup;
        ev_vec.err_passive = ev_err_passive;
        ev_vec.arb_lost    = ev_arb_lost;
        ev_vec.bus_err     = ev_bus_err;
    end

    can_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ev_vec),
        .wr_flag (wr && sel == SEL_FLAG),
        .wr_ien  (wr && sel == SEL_IEN),
        .wdata   (req_wdata[FLAG_W-1:0]),
        .flags_o (flags),
        .ien_o   (ien),
        .irq_o   (irq)
    );

    always_comb begin
        case (sel)
            SEL_MODE: rd_next = {27'd0, mode};
            SEL_STAT: rd_next = status;
            SEL_FLAG: rd_next = {24'd0, flags};
            SEL_IEN:  rd_next = {24'd0, ien};
            SEL_TIME: rd_next = timing;
            SEL_ERRC: rd_next = errc;
            default:  rd_next = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rd_q <= '0;
        else if (rd) rd_q <= rd_next;
    end

    assign rd_data    = rd_q;
    assign cfg_mode   = mode;
    assign cfg_timing = timing;
    assign cmd_pulse  = cmd_pulse_q;

    // R5: a strobe only appears after a command write made outside reset mode
    a_r5_cmd_gated: assert property (@(posedge clk) disable iff (rst)
        (cmd_pulse_q != '0) |-> ($past(wr) && !$past(mode.rst_mode)));

    // R6: transmit done leaves the transmit buffer ready
    a_r6_tbuf_ready: assert property (@(posedge clk) disable iff (rst)
        ev_tx_done |=> status[2] && status[3]);

endmodule

// File: tb/can_ctrl_regs_tb_top.sv
module can_ctrl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic ev_rx_frame = 0, ev_tx_done = 0, ev_err_warn = 0, ev_overrun = 0;
    logic ev_wakeup = 0, ev_err_passive = 0, ev_arb_lost = 0, ev_bus_err = 0;
    logic [1:0] berr_type = '0;
    logic       berr_dir = 0;
    logic [4:0] berr_seg = '0, arb_pos = '0;
    logic eng_rx_busy = 0, eng_tx_busy = 0, eng_bus_off = 0;
    logic tec_inc = 0, tec_dec = 0, rec_inc = 0, rec_dec = 0;
    logic [4:0]  cfg_mode;
    logic [31:0] cfg_timing;
    logic [5:0]  cmd_pulse;
    logic        irq;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    can_ctrl_regs dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rd_data;
    endtask

    task automatic pulse(ref logic sig, input int n);
        @(negedge clk);
        sig = 1;
        repeat (n) @(negedge clk);
        sig = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(8'h00, v); chk("R1 mode", v, 32'h01);
        rd_reg(8'h08, v); chk("R1 status", v, 32'h3C);
        rd_reg(8'h0C, v); chk("R1 flags", v, 0);
        rd_reg(8'h10, v); chk("R1 enable", v, 0);
        rd_reg(8'h1C, v); chk("R1 errc", v, 0);
        chk("R1 irq", irq, 0);
        rd_reg(8'h18, v); chk("R13 unmapped", v, 0);
        rd_reg(8'h04, v); chk("R5 cmd reads zero", v, 0);
    endtask

    task automatic t_mode;
        logic [31:0] v;
        wr_reg(8'h00, 32'h1F); rd_reg(8'h00, v); chk("R2 all bits in reset", v, 32'h1F);
        chk("R2 cfg_mode port", cfg_mode, 5'h1F);
        wr_reg(8'h00, 32'h06); rd_reg(8'h00, v); chk("R2 leave reset", v, 32'h06);
        wr_reg(8'h00, 32'h19); rd_reg(8'h00, v); chk("R2 bits 4:3 locked", v, 32'h01);
    endtask

    task automatic t_timing;
        logic [31:0] v;
        wr_reg(8'h14, 32'hFFFF_FFFF); rd_reg(8'h14, v); chk("R3 masked write", v, 32'h00FF_C3FF);
        wr_reg(8'h00, 32'h00);
        wr_reg(8'h14, 32'h0001_2345); rd_reg(8'h14, v); chk("R3 locked outside reset", v, 32'h00FF_C3FF);
        chk("R3 cfg_timing", cfg_timing, 32'h00FF_C3FF);
    endtask

    task automatic t_cmd_tx;
        logic [31:0] v;
        wr_reg(8'h00, 32'h01);
        wr_reg(8'h04, 32'h01);
        chk("R5 ignored in reset", cmd_pulse, 0);
        rd_reg(8'h08, v); chk("R5 status unchanged in reset", v, 32'h3C);
        wr_reg(8'h00, 32'h00);
        rd_reg(8'h08, v); chk("R4 busy low in normal", v, 32'h0C);
        wr_reg(8'h04, 32'h21);
        chk("R5 pulse", cmd_pulse, 6'h21);
        @(negedge clk); chk("R5 pulse one cycle", cmd_pulse, 0);
        rd_reg(8'h08, v); chk("R6 tx request clears", v, 32'h00);
        pulse(ev_tx_done, 1);
        rd_reg(8'h08, v); chk("R6 tx done sets", v, 32'h0C);
        rd_reg(8'h0C, v); chk("R6 tx flag", v, 32'h02);
        wr_reg(8'h04, 32'h10);
        wr_reg(8'h04, 32'h02);
        rd_reg(8'h08, v); chk("R6 abort sets ready only", v, 32'h04);
        wr_reg(8'h0C, 32'hFF);
        rd_reg(8'h0C, v); chk("R9 clear all", v, 0);
    endtask

    task automatic t_busy_errsta;
        logic [31:0] v;
        eng_tx_busy = 1; eng_bus_off = 1;
        rd_reg(8'h08, v); chk("R4 tx busy and bus off", v & 32'hA0, 32'hA0);
        eng_tx_busy = 0; eng_bus_off = 0; eng_rx_busy = 1;
        rd_reg(8'h08, v); chk("R4 rx busy", v & 32'hB0, 32'h10);
        eng_rx_busy = 0;
    endtask

    task automatic t_rx;
        logic [31:0] v;
        pulse(ev_rx_frame, 2);
        rd_reg(8'h08, v); chk("R7 ready", v, 32'h05);
        rd_reg(8'h0C, v); chk("R9 rx flag", v, 32'h01);
        wr_reg(8'h04, 32'h04);
        rd_reg(8'h08, v); chk("R7 one still pending", v & 1, 1);
        wr_reg(8'h04, 32'h04);
        rd_reg(8'h08, v); chk("R7 drained", v & 1, 0);
        pulse(ev_rx_frame, 5);
        rd_reg(8'h08, v); chk("R8 overrun on full", v, 32'h07);
        rd_reg(8'h0C, v); chk("R8 overrun flag", v & 32'h08, 32'h08);
        wr_reg(8'h04, 32'h08);
        rd_reg(8'h08, v); chk("R8 clear overrun", v, 32'h05);
        for (int i = 0; i < 4; i++) wr_reg(8'h04, 32'h04);
        rd_reg(8'h08, v); chk("R7 four released", v, 32'h04);
        pulse(ev_overrun, 1);
        rd_reg(8'h08, v); chk("R8 engine overrun", v, 32'h06);
        wr_reg(8'h04, 32'h08);
        wr_reg(8'h0C, 32'hFF);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr_reg(8'h10, 32'h02);
        pulse(ev_wakeup, 1);
        chk("R10 disabled flag", irq, 0);
        pulse(ev_tx_done, 1);
        chk("R10 enabled flag", irq, 1);
        wr_reg(8'h0C, 32'h02);
        chk("R10 cleared", irq, 0);
        rd_reg(8'h0C, v); chk("R9 other flag kept", v, 32'h10);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h0C; req_wdata = 32'h10; ev_wakeup = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; ev_wakeup = 0;
        rd_reg(8'h0C, v); chk("R9 set wins", v, 32'h10);
        wr_reg(8'h0C, 32'h10);
        rd_reg(8'h0C, v); chk("R9 w1c", v, 0);
        pulse(ev_err_warn, 1); pulse(ev_err_passive, 1);
        rd_reg(8'h0C, v); chk("R9 warn and passive flags", v, 32'h24);
        wr_reg(8'h10, 32'h20);
        chk("R10 passive enabled", irq, 1);
        wr_reg(8'h0C, 32'hFF);
        wr_reg(8'h10, 32'h00);
    endtask

    task automatic t_capture;
        logic [31:0] v;
        @(negedge clk);
        berr_type = 2'd2; berr_dir = 1; berr_seg = 5'h0A; arb_pos = 5'h13;
        ev_bus_err = 1; ev_arb_lost = 1;
        @(negedge clk);
        ev_bus_err = 0; ev_arb_lost = 0; berr_type = 0; berr_dir = 0; berr_seg = 0; arb_pos = 0;
        rd_reg(8'h08, v);
        chk("R11 error code", v[23:16], 32'hAA);
        chk("R11 arbitration position", v[12:8], 32'h13);
        rd_reg(8'h0C, v); chk("R11 flags", v, 32'hC0);
        wr_reg(8'h0C, 32'hFF);
    endtask

    task automatic t_counters;
        logic [31:0] v;
        pulse(tec_inc, 12);
        rd_reg(8'h08, v); chk("R4 warn bit at limit", v[6], 1);
        pulse(tec_inc, 20);
        pulse(rec_inc, 3);
        rd_reg(8'h1C, v); chk("R12 saturate and layout", v, 32'h0003_00FF);
        pulse(rec_dec, 5);
        pulse(tec_dec, 2);
        rd_reg(8'h1C, v); chk("R12 decrements", v, 32'h0000_00FD);
        wr_reg(8'h1C, 32'h5);
        rd_reg(8'h1C, v); chk("R12 nonzero write ignored", v, 32'h0000_00FD);
        wr_reg(8'h1C, 32'h0);
        rd_reg(8'h1C, v); chk("R12 clear", v, 0);
        rd_reg(8'h08, v); chk("R4 warn bit clear", v[6], 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_mode();
        t_timing();
        t_cmd_tx();
        t_busy_errsta();
        t_rx();
        t_irq();
        t_capture();
        t_counters();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule